// File: doc/BRIEF.md
# Serial Display Write Packet Decoder

This block sits behind a serial byte receiver (a chip-select framed SPI shifter or an I2C slave) and turns the received byte stream into single-cycle write commands for the memories of an on-screen-display controller. Each byte comes with a start-of-packet and an end-of-packet marker. The decoder classifies every byte as a row address, a column address or a data byte. It selects one of three target memories: the character code store, the attribute store or the user font RAM. It then issues a write strobe carrying the target, row, column and data.

Three packet formats share one state machine. In the first, each write has its own row, column and data bytes. In the second, a row is set once and column/data pairs follow. In the third, a single column byte opens a data burst, and the address advances on its own after every byte. Once a packet enters the burst format it stays there until the packet ends. With I2C framing, the first byte of each packet is the device address, and a packet with a foreign address is dropped.

Top module: `osd_pkt_decoder`

## Requirements
- R1: During and after reset, `wr_en` is low until a data byte is accepted.
- R2: A byte with bit 7 = 1 in the initial or column state is a row byte. If bit 6 = 1, the target becomes font RAM (code 2) and the row comes from bits 2..0. If bit 6 = 0, bit 5 picks character code (code 0, bit 5 = 0) or attribute (code 1, bit 5 = 1), and the row comes from bits 3..0.
- R3: A byte with bit 7 = 0 that follows a row byte or a data byte of the per-byte formats is a column byte. The column comes from bits 4..0 for character or attribute targets, and from bits 5..0 for the font target. Row and column bytes never raise `wr_en`.
- R4: If bit 6 of the column byte is 0, the next byte is data and is written at the latched target, row and column. After that data byte, a byte with bit 7 = 0 is a new column (pair format) and a byte with bit 7 = 1 is a new row.
- R5: If bit 6 of the column byte is 1, every later byte of the packet is data, including bytes with bit 7 = 1.
- R6: In the burst format, the column advances by one after each write. Past the last column (29 for character/attribute, 63 for font) the column wraps to 0 and the row advances. Past the last row (14, or 7 for font) the row wraps to 0.
- R7: A byte marked end-of-packet is processed, and the machine then returns to the initial state. In the initial state a byte with bit 7 = 0 is ignored and causes no write.
- R8: A byte marked start-of-packet is decoded from the initial state, whatever state an earlier packet left behind.
- R9: With `frame_i2c` high, the start-of-packet byte is a device address and never causes a write. If it equals 7Ah, decoding continues normally. If it differs, every byte up to the end of the packet is ignored.
- R10: Each accepted data byte produces exactly one `wr_en` pulse, one clock after the byte is sampled, carrying that byte on `wr_data`. No pulse appears in a cycle without a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i2c | input | 1 | 1: packets begin with a device address byte |
| in_valid | input | 1 | A received byte is present this cycle |
| in_byte | input | 8 | Received byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| wr_en | output | 1 | Write strobe, one cycle per data byte |
| wr_target | output | 2 | 0 character code, 1 attribute, 2 font RAM |
| wr_row | output | 4 | Row of the write |
| wr_col | output | 6 | Column of the write |
| wr_data | output | 8 | Byte to write |

## Verification
A wrong format state shows up at the latest on the next data byte. A byte that should be data is taken as a new address (a write is missing), or an address byte is taken as data (a spurious strobe appears). Address-latch or increment faults show up on the first write after the fault as a wrong row, column or target. Wrap faults appear only at the last column of a row, so bursts are started next to both edges of each target. A lost return to the initial state shows up on the first byte of the next packet.

// File: rtl/osd_dec_pkg.sv
package osd_dec_pkg;
   localparam int ROW_W = 4;
   localparam int COL_W = 6;

   typedef enum logic [1:0] {
      TGT_CHAR = 2'd0,
      TGT_ATTR = 2'd1,
      TGT_FONT = 2'd2
   } tgt_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_COL    = 3'd1,
      ST_DATA   = 3'd2,
      ST_STREAM = 3'd3,
      ST_DROP   = 3'd4
   } fmt_st_e;
endpackage

// File: rtl/osd_byte_fields.sv
module osd_byte_fields
   import osd_dec_pkg::*;
(
   input  logic [7:0]       b,
   output tgt_e             row_tgt,
   output logic [ROW_W-1:0] row_num,
   output logic [COL_W-1:0] col_disp,
   output logic [COL_W-1:0] col_font,
   output logic             col_burst
);
   always_comb begin
      if (b[6]) begin
         row_tgt = TGT_FONT;
         row_num = {1'b0, b[2:0]};
      end else begin
         row_tgt = b[5] ? TGT_ATTR : TGT_CHAR;
         row_num = b[3:0];
      end
   end

   assign col_disp  = {1'b0, b[4:0]};
   assign col_font  = b[5:0];
   assign col_burst = b[6];
endmodule

// File: rtl/osd_fmt_fsm.sv
module osd_fmt_fsm
   import osd_dec_pkg::*;
#(
   parameter logic [7:0] SLAVE_ADDR = 8'h7A
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_i2c,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   input  logic       in_sop,
   input  logic       in_eop,
   output logic       ld_row,
   output logic       ld_col,
   output logic       wr_fire,
   output logic       adv
);
   fmt_st_e state_q, state_d, eff_st;

   always_comb begin
      eff_st  = in_sop ? ST_IDLE : state_q;
      state_d = state_q;
      ld_row  = 1'b0;
      ld_col  = 1'b0;
      wr_fire = 1'b0;
      adv     = 1'b0;
      if (in_valid) begin
         if (in_sop && frame_i2c) begin
            state_d = (in_byte == SLAVE_ADDR) ? ST_IDLE : ST_DROP;
         end else begin
            case (eff_st)
               ST_IDLE: begin
                  if (in_byte[7]) begin
                     ld_row  = 1'b1;
                     state_d = ST_COL;
                  end else begin
                     state_d = ST_IDLE;
                  end
               end
               ST_COL: begin
                  if (in_byte[7]) begin
                     ld_row  = 1'b1;
                     state_d = ST_COL;
                  end else begin
                     ld_col  = 1'b1;
                     state_d = in_byte[6] ? ST_STREAM : ST_DATA;
                  end
               end
               ST_DATA: begin
                  wr_fire = 1'b1;
                  state_d = ST_COL;
               end
               ST_STREAM: begin
                  wr_fire = 1'b1;
                  adv     = 1'b1;
                  state_d = ST_STREAM;
               end
               default: state_d = ST_DROP;
            endcase
         end
         if (in_eop) state_d = ST_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   p_stream_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STREAM && !(in_valid && (in_sop || in_eop)))
      |=> state_q == ST_STREAM);

   p_eop_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eop) |=> state_q == ST_IDLE);

   p_bad_addr_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop && frame_i2c && in_byte != SLAVE_ADDR && !in_eop)
      |=> state_q == ST_DROP);
endmodule

// File: rtl/osd_wr_addr.sv
module osd_wr_addr
   import osd_dec_pkg::*;
#(
   parameter int ROWS      = 15,
   parameter int COLS      = 30,
   parameter int FONT_ROWS = 8,
   parameter int FONT_COLS = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       in_byte,
   input  logic             ld_row,
   input  logic             ld_col,
   input  logic             adv,
   output tgt_e             tgt_q,
   output logic [ROW_W-1:0] row_q,
   output logic [COL_W-1:0] col_q
);
   localparam logic [ROW_W-1:0] DISP_ROW_LAST = ROW_W'(ROWS - 1);
   localparam logic [COL_W-1:0] DISP_COL_LAST = COL_W'(COLS - 1);
   localparam logic [ROW_W-1:0] FONT_ROW_LAST = ROW_W'(FONT_ROWS - 1);
   localparam logic [COL_W-1:0] FONT_COL_LAST = COL_W'(FONT_COLS - 1);

   tgt_e             f_tgt;
   logic [ROW_W-1:0] f_row;
   logic [COL_W-1:0] f_col_disp, f_col_font;
   logic             f_burst;
   logic [ROW_W-1:0] row_last;
   logic [COL_W-1:0] col_last;

   osd_byte_fields u_fields (
      .b        (in_byte),
      .row_tgt  (f_tgt),
      .row_num  (f_row),
      .col_disp (f_col_disp),
      .col_font (f_col_font),
      .col_burst(f_burst)
   );

   assign row_last = (tgt_q == TGT_FONT) ? FONT_ROW_LAST : DISP_ROW_LAST;
   assign col_last = (tgt_q == TGT_FONT) ? FONT_COL_LAST : DISP_COL_LAST;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q <= TGT_CHAR;
         row_q <= '0;
         col_q <= '0;
      end else if (ld_row) begin
         tgt_q <= f_tgt;
         row_q <= f_row;
      end else if (ld_col) begin
         col_q <= (tgt_q == TGT_FONT) ? f_col_font : f_col_disp;
      end else if (adv) begin
         if (col_q >= col_last) begin
            col_q <= '0;
            row_q <= (row_q >= row_last) ? '0 : row_q + 1'b1;
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end

   p_col_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && col_q < col_last) |=> (col_q == $past(col_q) + 1'b1) && $stable(row_q));

   p_row_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && col_q >= col_last && row_q >= row_last) |=> (row_q == '0) && (col_q == '0));
endmodule

// File: rtl/osd_pkt_decoder.sv
module osd_pkt_decoder
   import osd_dec_pkg::*;
#(
   parameter int         ROWS       = 15,
   parameter int         COLS       = 30,
   parameter int         FONT_ROWS  = 8,
   parameter int         FONT_COLS  = 64,
   parameter logic [7:0] SLAVE_ADDR = 8'h7A,
   parameter bit         OUT_REG    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_i2c,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   input  logic       in_sop,
   input  logic       in_eop,
   output logic       wr_en,
   output logic [1:0] wr_target,
   output logic [3:0] wr_row,
   output logic [5:0] wr_col,
   output logic [7:0] wr_data
);
   generate
      if (ROWS < 1 || ROWS > (1 << ROW_W)) begin : g_chk_rows
         $error("ROWS must lie in 1..16");
      end
      if (COLS < 1 || COLS > 32) begin : g_chk_cols
         $error("COLS must lie in 1..32");
      end
      if (FONT_ROWS < 1 || FONT_ROWS > 8) begin : g_chk_frows
         $error("FONT_ROWS must lie in 1..8");
      end
      if (FONT_COLS < 1 || FONT_COLS > (1 << COL_W)) begin : g_chk_fcols
         $error("FONT_COLS must lie in 1..64");
      end
   endgenerate

   logic             ld_row, ld_col, fire, adv;
   tgt_e             tgt_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;

   osd_fmt_fsm #(.SLAVE_ADDR(SLAVE_ADDR)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_i2c(frame_i2c),
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .in_sop   (in_sop),
      .in_eop   (in_eop),
      .ld_row   (ld_row),
      .ld_col   (ld_col),
      .wr_fire  (fire),
      .adv      (adv)
   );

   osd_wr_addr #(
      .ROWS     (ROWS),
      .COLS     (COLS),
      .FONT_ROWS(FONT_ROWS),
      .FONT_COLS(FONT_COLS)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_byte(in_byte),
      .ld_row (ld_row),
      .ld_col (ld_col),
      .adv    (adv),
      .tgt_q  (tgt_q),
      .row_q  (row_q),
      .col_q  (col_q)
   );

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_en     <= 1'b0;
               wr_target <= TGT_CHAR;
               wr_row    <= '0;
               wr_col    <= '0;
               wr_data   <= '0;
            end else begin
               wr_en <= fire;
               if (fire) begin
                  wr_target <= tgt_q;
                  wr_row    <= row_q;
                  wr_col    <= col_q;
                  wr_data   <= in_byte;
               end
            end
         end

         p_wr_from_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> $past(in_valid));
      end else begin : g_out_comb
         assign wr_en     = fire;
         assign wr_target = tgt_q;
         assign wr_row    = row_q;
         assign wr_col    = col_q;
         assign wr_data   = in_byte;

         p_wr_with_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> in_valid);
      end
   endgenerate

   p_target_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_target != 2'd3);
endmodule

// File: tb/osd_pkt_decoder_tb_top.sv
`timescale 1ns/1ps
module osd_pkt_decoder_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_i2c = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       in_sop = 1'b0;
   logic       in_eop = 1'b0;
   logic       wr_en;
   logic [1:0] wr_target;
   logic [3:0] wr_row;
   logic [5:0] wr_col;
   logic [7:0] wr_data;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // reference state: 0 initial, 1 column, 2 data, 3 burst, 4 drop
   int       m_st = 0;
   int       m_tgt = 0;
   int       m_row = 0;
   int       m_col = 0;

   always #4 clk = ~clk;

   osd_pkt_decoder dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_i2c(frame_i2c),
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .in_sop   (in_sop),
      .in_eop   (in_eop),
      .wr_en    (wr_en),
      .wr_target(wr_target),
      .wr_row   (wr_row),
      .wr_col   (wr_col),
      .wr_data  (wr_data)
   );

   function automatic int last_col(int t);
      return (t == 2) ? 63 : 29;
   endfunction

   function automatic int last_row(int t);
      return (t == 2) ? 7 : 14;
   endfunction

   // expected write for one byte, from the requirements
   task automatic model(input logic [7:0] b, input bit sop, input bit eop,
                        output bit en, output int t, output int r, output int c);
      int st, nx;
      en = 0; t = m_tgt; r = m_row; c = m_col;
      st = sop ? 0 : m_st;
      nx = st;
      if (sop && frame_i2c) begin
         nx = (b == 8'h7A) ? 0 : 4;
      end else begin
         case (st)
            0, 1: begin
               if (b[7]) begin
                  if (b[6]) begin m_tgt = 2; m_row = b[2:0]; end
                  else begin m_tgt = b[5] ? 1 : 0; m_row = b[3:0]; end
                  nx = 1;
               end else if (st == 1) begin
                  m_col = (m_tgt == 2) ? int'(b[5:0]) : int'(b[4:0]);
                  nx = b[6] ? 3 : 2;
               end
            end
            2: begin
               en = 1; t = m_tgt; r = m_row; c = m_col; nx = 1;
            end
            3: begin
               en = 1; t = m_tgt; r = m_row; c = m_col;
               if (m_col >= last_col(m_tgt)) begin
                  m_col = 0;
                  m_row = (m_row >= last_row(m_tgt)) ? 0 : m_row + 1;
               end else begin
                  m_col = m_col + 1;
               end
            end
            default: nx = 4;
         endcase
      end
      if (eop) nx = 0;
      m_st = nx;
   endtask

   // called at a falling edge; returns at the next falling edge after checking
   task automatic send(input logic [7:0] b, input bit sop, input bit eop, input string req);
      bit en; int t, r, c;
      model(b, sop, eop, en, t, r, c);
      in_valid = 1'b1; in_byte = b; in_sop = sop; in_eop = eop;
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      total++;
      if (en) begin
         if (!(wr_en === 1'b1 && wr_target == t[1:0] && wr_row == r[3:0] &&
               wr_col == c[5:0] && wr_data == b)) begin
            bad++;
            $display("FAIL %s: byte %02h got en=%0b t=%0d r=%0d c=%0d d=%02h exp en=1 t=%0d r=%0d c=%0d d=%02h",
                     req, b, wr_en, wr_target, wr_row, wr_col, wr_data, t, r, c, b);
         end
      end else if (wr_en !== 1'b0) begin
         bad++;
         $display("FAIL %s: byte %02h got en=%0b exp en=0", req, b, wr_en);
      end
   endtask

   task automatic idle(input string req);
      in_valid = 1'b0;
      @(negedge clk);
      total++;
      if (wr_en !== 1'b0) begin
         bad++;
         $display("FAIL %s: idle cycle got en=%0b exp en=0", req, wr_en);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: run did not finish, got timeout exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0d15));
      repeat (4) @(negedge clk);
      total++;
      if (wr_en !== 1'b0) begin
         bad++;
         $display("FAIL R1: during reset got en=%0b exp en=0", wr_en);
      end
      rst_n = 1'b1;
      idle("R1");

      // R7: data before any row is dropped
      send(8'h05, 1, 0, "R7");
      // R2 / R4: character row 3, column 7, one data byte
      send(8'h83, 0, 0, "R2");
      send(8'h07, 0, 0, "R3");
      send(8'h41, 0, 0, "R4");
      // R4: pair format on the same row
      send(8'h09, 0, 0, "R4");
      send(8'h42, 0, 0, "R4");
      // R2: attribute row 2, then new column and data
      send(8'hA2, 0, 0, "R2");
      send(8'h01, 0, 0, "R3");
      send(8'h55, 0, 0, "R2");
      // R3: display column keeps bits 4..0 only (3Fh -> 31)
      send(8'h81, 0, 0, "R2");
      send(8'h3F, 0, 0, "R3");
      send(8'h66, 0, 0, "R3");
      // R3: font row 5, column 63
      send(8'hC5, 0, 0, "R2");
      send(8'h3F, 0, 0, "R3");
      send(8'h77, 0, 1, "R3");
      idle("R10");
      // R5 / R6: burst from character row 14 col 28 across both wraps
      send(8'h8E, 1, 0, "R8");
      send(8'h5C, 0, 0, "R5");
      send(8'h10, 0, 0, "R6");
      send(8'h9A, 0, 0, "R5");
      send(8'hC3, 0, 0, "R6");
      send(8'h12, 0, 1, "R6");
      // R7: after end of packet a data-like byte writes nothing
      send(8'h33, 1, 0, "R7");
      idle("R10");
      // R6: font burst from row 7 col 63
      send(8'hC7, 0, 0, "R2");
      send(8'h7F, 0, 0, "R5");
      send(8'hA0, 0, 0, "R6");
      send(8'hA1, 0, 0, "R6");
      // R8: new packet cuts a burst; its data-like first byte is ignored
      send(8'h10, 1, 0, "R8");
      send(8'h84, 0, 0, "R8");
      send(8'h02, 0, 0, "R8");
      send(8'h11, 0, 1, "R8");
      // R9: address framing
      frame_i2c = 1'b1;
      send(8'h7A, 1, 0, "R9");
      send(8'h81, 0, 0, "R9");
      send(8'h03, 0, 0, "R9");
      send(8'h66, 0, 1, "R9");
      send(8'h7C, 1, 0, "R9");
      send(8'h81, 0, 0, "R9");
      send(8'h03, 0, 0, "R9");
      send(8'h66, 0, 1, "R9");
      send(8'h81, 1, 0, "R9");
      send(8'h43, 0, 0, "R9");
      send(8'h67, 0, 1, "R9");
      idle("R10");

      // random packets, both framings
      for (int p = 0; p < 400; p++) begin
         int len;
         frame_i2c = (p >= 200);
         len = 1 + ($urandom % 30);
         for (int k = 0; k < len; k++) begin
            logic [7:0] b;
            bit eop;
            b = 8'($urandom);
            if (k == 0 && frame_i2c && ($urandom % 5 != 0)) b = 8'h7A;
            eop = (k == len - 1) && ($urandom % 10 != 0);
            send(b, (k == 0), eop, "R10");
            if ($urandom % 6 == 0) idle("R10");
         end
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule